// File: doc/BRIEF.md
# Five-Port GPIO Bank with Mixed Direction Granularity

This block controls five 8-bit general-purpose I/O ports from a simple register bus with address, write enable, an operation code, write data and combinational read data. Each port gives its direction control a different granularity. The first port has one control bit per half-port. The second has one bit for the whole port. The third and fifth have one bit per pin. The fourth has a fixed split: its lower four pins are inputs and its upper four pins are outputs. Toward the pad models the block drives output enable, output value and pull-up enable for each pin. It samples each pad level through a two-flop synchronizer.

A read of a data register always returns the synchronized pad levels and never the output latch. Read-modify-write operations (AND, OR, XOR) combine the current pad levels with the bus data and store the result in the latch. A per-port open-drain select turns a latch value of 1 into a released pad. With its pull-up forced off, such a pin reads back 0 when nothing outside drives it.

Top module: `gpio_bank5`

## Requirements
- R1: After reset the block is in its default state.
    - All latches and direction bits are 0 and no port is open-drain.
    - Every configurable pin is an input with its pull-up on.
    - The fixed port's lower pins have pull-ups on. Its upper pins have output enable on and drive 0.
    - At the ports: pad_oe = 40'h00F0000000, pad_pu = 40'hFF0FFFFFFF and pad_out = 0.
- R2: Port p occupies bits [8p+7:8p] of every pad vector.
    - Port p's data register is at address 2p. Its mode register is at address 2p+1.
    - The open-drain select is at address 10, with bit p covering port p.
    - bus_op encodes 0 = write, 1 = AND, 2 = OR, 3 = XOR.
- R3: Port 0 mode register:
    - Bit 0 set makes pins 0–3 outputs.
    - Bit 1 set makes pins 4–7 outputs.
    - It reads back only bits 1:0.
- R4: Port 1 mode register bit 0 sets the direction of all eight pins. It reads back only bit 0.
- R5: Ports 2 and 4 have one mode bit per pin, and 1 means output.
- R6: Port 3 has fixed directions.
    - Pins 0–3 are never driven.
    - Pins 4–7 always have output enable on.
    - Its mode register reads 0 and ignores writes.
    - Writes to its data register affect only the upper four latch bits.
- R7: On ports 0, 1, 2 and 4, a pin's pull-up is off whenever the pin is an output and on whenever it is an input.
- R8: A push-pull output pin has output enable on and drives its latch value.
- R9: On an open-drain port, an output pin behaves by its latch value.
    - With latch 0 it has output enable on and drives 0.
    - With latch 1 it has output enable off. Its pull-up is off, so with nothing driving the pad it reads 0.
- R10: A data register read returns the pad levels through a two-flop synchronizer. A pad change becomes visible after the second rising clock edge, whatever the latch holds.
- R11: A non-write operation has a scope that depends on the address.
    - At a data address it stores (synchronized pins op bus_wdata) into the latch.
    - At any other address it has no effect.
- R12: Unused or unmapped locations behave as empty.
    - Mode bits that do not exist read 0 and ignore writes.
    - Addresses 11–15 read 0 and ignore writes.
    - Bits 7:5 of the open-drain select read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_op | input | 2 | 0 write, 1 AND, 2 OR, 3 XOR |
| bus_wdata | input | 8 | Write data or operand |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 40 | Pad levels, port p at [8p+7:8p] |
| pad_oe | output | 40 | Pad output enable |
| pad_out | output | 40 | Pad output value |
| pad_pu | output | 40 | Pad pull-up enable |

## Verification
A wrong direction or open-drain bit shows up at pad_oe and pad_pu in the very cycle after the write that set it. Through the pad loop it reaches bus_rdata two edges later. A corrupted latch shows on pad_out at once, but only for output pins. For input pins it stays hidden until a read-modify-write or a change of direction exposes it. For that reason the bench drives pins externally and checks that a read-modify-write result follows the pins rather than the stale latch. A synchronizer with the wrong depth shifts read data by one cycle, and the latency check at edge one and at edge two catches it.

// File: rtl/gpio_bank_pkg.sv
// Shared constants, encodings and helper functions for the GPIO bank.
// Assumes 8-pin ports with an even pin count, so that a port splits into two halves.
package gpio_bank_pkg;
    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 5;
    localparam int ADDR_W    = 4;
    localparam int OD_ADDR   = 2 * NUM_PORTS;
    localparam int HALF_W    = PORT_W / 2;

    typedef enum logic [1:0] {OP_WRITE, OP_AND, OP_OR, OP_XOR} bus_op_e;
    typedef enum logic [1:0] {DIR_HALF, DIR_WHOLE, DIR_PIN, DIR_FIXED} dir_mode_e;

    // Direction granularity assigned to each port index.
    function automatic dir_mode_e port_mode(input int idx);
        case (idx)
            0:       return DIR_HALF;
            1:       return DIR_WHOLE;
            3:       return DIR_FIXED;
            default: return DIR_PIN;
        endcase
    endfunction

    // Writable bits of a port's mode register.
    function automatic logic [PORT_W-1:0] dir_mask(input dir_mode_e m);
        case (m)
            DIR_HALF:  return PORT_W'(2'b11);
            DIR_WHOLE: return PORT_W'(1'b1);
            DIR_PIN:   return {PORT_W{1'b1}};
            default:   return '0;
        endcase
    endfunction

    // Writable bits of a port's output latch.
    function automatic logic [PORT_W-1:0] latch_mask(input dir_mode_e m);
        return (m == DIR_FIXED) ? {{HALF_W{1'b1}}, {HALF_W{1'b0}}} : {PORT_W{1'b1}};
    endfunction

    // Combine pin levels and bus data according to the operation.
    function automatic logic [PORT_W-1:0] apply_op(input bus_op_e op,
                                                   input logic [PORT_W-1:0] pins,
                                                   input logic [PORT_W-1:0] wdata);
        case (op)
            OP_AND:  return pins & wdata;
            OP_OR:   return pins | wdata;
            OP_XOR:  return pins ^ wdata;
            default: return wdata;
        endcase
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for pad levels.
// The flops carry no reset, so after the first two edges the output is an exact two-cycle delay of the input.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    // Shift the pad levels through two stages.
    always_ff @(posedge clk) begin
        s1_q <= d;
        s2_q <= s1_q;
    end

    assign q = s2_q;

    // R10
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q == $past(d, 2));
endmodule

// File: rtl/gpio_port.sv
// One 8-pin port: output latch, mode register, direction decode,
// pull-up gating and the drive rule for push-pull or open-drain pins.
// Assumes the bus strobes data_we and mode_we for only one cycle per access.
module gpio_port
    import gpio_bank_pkg::*;
#(
    parameter dir_mode_e MODE = DIR_PIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic              mode_we,
    input  bus_op_e           op,
    input  logic [PORT_W-1:0] wdata,
    input  logic              od,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pin_lvl,
    output logic [PORT_W-1:0] mode_rd,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu
);
    localparam logic [PORT_W-1:0] DMASK = dir_mask(MODE);
    localparam logic [PORT_W-1:0] LMASK = latch_mask(MODE);

    logic [PORT_W-1:0] dir_q, latch_q, dir_exp;

    gpio_sync #(.W(PORT_W)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (pin_lvl)
    );

    // Mode register: only a plain write changes it, and only its defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                         dir_q <= '0;
        else if (mode_we && op == OP_WRITE) dir_q <= wdata & DMASK;
    end

    // Output latch: a write or a read-modify-write of the synchronized pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (data_we) latch_q <= apply_op(op, pin_lvl, wdata) & LMASK;
    end

    // Expand the mode bits into a per-pin output flag, by granularity.
    generate
        if (MODE == DIR_HALF) begin : g_half
            assign dir_exp = {{HALF_W{dir_q[1]}}, {HALF_W{dir_q[0]}}};
        end else if (MODE == DIR_WHOLE) begin : g_whole
            assign dir_exp = {PORT_W{dir_q[0]}};
        end else if (MODE == DIR_PIN) begin : g_pin
            assign dir_exp = dir_q;
        end else begin : g_fixed
            assign dir_exp = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
        end
    endgenerate

    // Drive rule: an open-drain pin releases the pad for latch 1 and drives 0 otherwise.
    assign pad_oe  = dir_exp & ~({PORT_W{od}} & latch_q);
    assign pad_out = latch_q & ~{PORT_W{od}};
    assign pad_pu  = ~dir_exp;
    assign mode_rd = dir_q;

    // R11
    rmw_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && op == OP_AND) |=> latch_q == ($past(pin_lvl & wdata) & LMASK));
    // R9
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & latch_q & {PORT_W{od}}) == '0);
    // R7
    pu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);
    // R12
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_we && op == OP_WRITE) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_bank5.sv
// Five-port GPIO bank: address decode, open-drain select register,
// per-port instances and the read multiplexer.
// Assumes a single-cycle bus write strobe; reads are combinational from bus_addr.
module gpio_bank5
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_we,
    input  logic [1:0]  bus_op,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [39:0] pad_in,
    output logic [39:0] pad_oe,
    output logic [39:0] pad_out,
    output logic [39:0] pad_pu
);
    logic [NUM_PORTS-1:0] od_q;
    logic [PORT_W-1:0]    pin_lvl [NUM_PORTS];
    logic [PORT_W-1:0]    mode_rd [NUM_PORTS];
    bus_op_e              op;

    assign op = bus_op_e'(bus_op);

    // Open-drain select: a plain write at its address updates it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            od_q <= '0;
        else if (bus_we && bus_addr == ADDR_W'(OD_ADDR) && op == OP_WRITE)
            od_q <= bus_wdata[NUM_PORTS-1:0];
    end

    // One port instance per index, with its direction granularity.
    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
            gpio_port #(.MODE(port_mode(g))) port_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .data_we(bus_we && bus_addr == ADDR_W'(2 * g)),
                .mode_we(bus_we && bus_addr == ADDR_W'(2 * g + 1)),
                .op     (op),
                .wdata  (bus_wdata),
                .od     (od_q[g]),
                .pad_in (pad_in[g*PORT_W +: PORT_W]),
                .pin_lvl(pin_lvl[g]),
                .mode_rd(mode_rd[g]),
                .pad_oe (pad_oe[g*PORT_W +: PORT_W]),
                .pad_out(pad_out[g*PORT_W +: PORT_W]),
                .pad_pu (pad_pu[g*PORT_W +: PORT_W])
            );
        end
    endgenerate

    // Read multiplexer: pin levels, mode registers, open-drain select, else 0.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == ADDR_W'(2 * p))     bus_rdata = pin_lvl[p];
            if (bus_addr == ADDR_W'(2 * p + 1)) bus_rdata = mode_rd[p];
        end
        if (bus_addr == ADDR_W'(OD_ADDR)) bus_rdata = PORT_W'(od_q);
    end

    // R2
    od_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OD_ADDR) && bus_op == 2'd0)
        |=> od_q == $past(bus_wdata[NUM_PORTS-1:0]));
    // R6
    fixed_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[3*PORT_W +: HALF_W] == '0);
endmodule

// File: tb/gpio_bank5_tb.sv
// Bench: pad model, vector table walk, then directed checks of pads, latency and RMW.
module gpio_bank5_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_op = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [39:0] pad_in, pad_oe, pad_out, pad_pu;
    logic [39:0] ext_en = '0, ext_val = '0;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    // Pad model: driver first, then external source, then pull-up, else floats to 0.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_en & ext_val)
                  | (~pad_oe & ~ext_en & pad_pu);

    gpio_bank5 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // {addr, op, wdata, check addr, expected, requirement number}
    localparam logic [29:0] VEC [18] = '{
        {4'd15, 2'd0, 8'h55, 4'd0,  8'hFF, 4'd12}, // R12 R1
        {4'd1,  2'd0, 8'h01, 4'd0,  8'hF0, 4'd3},  // R3
        {4'd1,  2'd0, 8'hFD, 4'd1,  8'h01, 4'd3},  // R3 R12
        {4'd0,  2'd0, 8'h0A, 4'd0,  8'hFA, 4'd10}, // R10
        {4'd0,  2'd3, 8'hFF, 4'd0,  8'hF5, 4'd11}, // R11
        {4'd3,  2'd0, 8'h01, 4'd2,  8'h00, 4'd4},  // R4
        {4'd2,  2'd0, 8'hC3, 4'd2,  8'hC3, 4'd8},  // R8
        {4'd2,  2'd2, 8'h0C, 4'd2,  8'hCF, 4'd11}, // R11
        {4'd5,  2'd0, 8'h81, 4'd4,  8'h7E, 4'd5},  // R5
        {4'd5,  2'd1, 8'h00, 4'd5,  8'h81, 4'd11}, // R11
        {4'd7,  2'd0, 8'hFF, 4'd7,  8'h00, 4'd6},  // R6
        {4'd6,  2'd0, 8'hA5, 4'd6,  8'hAF, 4'd6},  // R6
        {4'd10, 2'd0, 8'h04, 4'd10, 8'h04, 4'd2},  // R2
        {4'd4,  2'd0, 8'h81, 4'd4,  8'h7E, 4'd9},  // R9
        {4'd4,  2'd1, 8'hFF, 4'd4,  8'h7E, 4'd11}, // R11
        {4'd9,  2'd0, 8'hF0, 4'd8,  8'h0F, 4'd5},  // R5
        {4'd8,  2'd0, 8'h30, 4'd8,  8'h3F, 4'd5},  // R5
        {4'd11, 2'd0, 8'hFF, 4'd11, 8'h00, 4'd12}  // R12
    };

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [1:0] o, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_op = o; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_op = 2'd0;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, {32'd0, bus_rdata}, {32'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the pads
        chk("R1 oe", pad_oe, 40'h00F0000000);
        chk("R1 pu", pad_pu, 40'hFF0FFFFFFF);
        chk("R1 out", pad_out, 40'h0);
        read_chk("R1 mode", 4'd1, 8'h00);

        for (int i = 0; i < 18; i++) begin
            bus_write(VEC[i][29:26], VEC[i][25:24], VEC[i][23:16]);
            read_chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][15:12], VEC[i][11:4]);
        end

        // R7 R8 port 0 pads: lower half output, push-pull, latch 05
        chk("R8 p0 oe", {32'd0, pad_oe[7:0]}, 40'h0F);
        chk("R8 p0 out", {32'd0, pad_out[7:0]}, 40'h05);
        chk("R7 p0 pu", {32'd0, pad_pu[7:0]}, 40'hF0);
        // R9 port 2 open-drain, outputs on pins 0 and 7 with latch 0
        chk("R9 p2 oe", {32'd0, pad_oe[23:16]}, 40'h81);
        chk("R9 p2 out", {32'd0, pad_out[23:16]}, 40'h00);
        chk("R7 p2 pu", {32'd0, pad_pu[23:16]}, 40'h7E);
        // R6 fixed port pads
        chk("R6 p3 oe", {32'd0, pad_oe[31:24]}, 40'hF0);
        chk("R6 p3 out", {32'd0, pad_out[31:24]}, 40'hA0);
        chk("R6 p3 pu", {32'd0, pad_pu[31:24]}, 40'h0F);

        // R10 latency: port 1 to input, then drive it externally
        bus_write(4'd3, 2'd0, 8'h00);
        read_chk("R7 p1 input", 4'd2, 8'hFF);
        ext_en[15:8] = 8'hFF; ext_val[15:8] = 8'h5A;
        @(negedge clk);
        read_chk("R10 edge1", 4'd2, 8'hFF);
        @(negedge clk);
        read_chk("R10 edge2", 4'd2, 8'h5A);

        // R11 RMW uses pins (5A), not the stale latch (CF)
        bus_write(4'd2, 2'd2, 8'h01);
        bus_write(4'd3, 2'd0, 8'h01);
        ext_en[15:8] = 8'h00;
        repeat (3) @(negedge clk);
        read_chk("R11 pins", 4'd2, 8'h5B);

        // R6 R10 fixed port inputs driven externally
        ext_en[27:24] = 4'hF; ext_val[27:24] = 4'h3;
        repeat (3) @(negedge clk);
        read_chk("R6 p3 in", 4'd6, 8'hA3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule